// File: doc/BRIEF.md
# Serial Port Register File with Interrupt

This block is the memory-mapped control and status front end of a simple serial port. A 32-bit bus reaches a set of 16-bit registers through word-aligned offsets. The set holds four control words, two status words, a queue-control word, the baud modulator and baud count, a one-millisecond word, and a read-only test/status word. A byte-stream input delivers received characters and line-break events into a one-character holding buffer. Bus writes to the transmit offset leave on a valid/ready byte-stream output, but only while the transmitter is enabled. A single registered, level-sensitive interrupt line combines the status bits that the control words enable.

Two small state machines carry the data paths. The receive machine has the states EMPTY and FULL. EMPTY moves to FULL when a character or break is accepted (transition ACCEPT). FULL moves back to EMPTY when the bus reads the receive offset (transition TAKE). The transmit machine has the states IDLE and HOLD. IDLE moves to HOLD when an enabled transmit write arrives (transition LOAD). HOLD moves back to IDLE when the sink takes the byte (transition SEND). A soft reset (transition WIPE) sends both machines to EMPTY and IDLE from any state.

Baud generation, serial framing, queues, DMA and modem lines are outside this block.

Top module: `sercsr_top`

## Requirements
- R1: After reset the reads return: control-1 0x0000, control-2 0x0001, control-3 0x0700, modulator 0x0000, baud count 0x0004, status-1 0x6040, status-2 0x4028, test/status 0x0060, and receive data 0x4000. At the same time `irq` is 0, `rx_ready` is 1 and `tx_valid` is 0.
- R2: The word index is `bus_addr[11:2]`. The byte offsets are:
  - 0x000 receive data, 0x040 transmit data;
  - 0x080, 0x084, 0x088, 0x08C control-1 to control-4;
  - 0x090 queue control, 0x094 status-1, 0x098 status-2;
  - 0x0A4 baud incremental, 0x0A8 modulator, 0x0AC baud count;
  - 0x0B0 one-millisecond, 0x0B4 test/status.

  Control, queue-control, modulator and one-millisecond writes store the low 16 bits and read them back. A baud-incremental write lands in the baud count, and the incremental offset reads 0. Writes to baud count and test/status are ignored. Unknown offsets read 0 and ignore writes.
- R3: `rx_ready` is 1 only while the buffer is empty. An accepted character is stored as 0x00cc and sets status-1 bit 9 (receive-ready) and status-2 bit 0 (data-ready). It also clears test/status bit 5 (RX-empty). A character offered while the buffer is full is ignored.
- R4: A receive-data read while the buffer is full returns the stored word with bit 15 (char-ready) set. It empties the buffer. A read of an empty buffer returns the stored word without bit 15 and changes nothing.
- R5: A break input is stored as 0x5800: bit 11 break, bit 12 frame error, bit 14 error. It also sets status-2 bit 2 (break-detect).
- R6: Writing 1 to status-1 bits 4, 5, 7, 8, 10, 11, 12 and 15 (mask 0x9DB0) clears them. All other status-1 bits ignore writes.
- R7: Writing 1 to status-2 bits 1, 2, 4, 6, 7, 8, 10, 11, 12, 13 and 15 (mask 0xBDD6) clears them. All other status-2 bits ignore writes.
- R8: A transmit write while control-2 bit 2 (TX enable) is 1 presents the low byte on `tx_data` with `tx_valid` high, held stable until `tx_ready`. Status-1 bit 13 (transmit-ready) and status-2 bit 3 (transmit-complete) read 0 while the byte waits. Both return to 1 after the handshake.
- R9: A transmit write is dropped when TX enable is 0, and also while a byte is still waiting.
- R10: `irq` follows, one cycle after the state it reflects, the OR of status-1 AND control-1 over bits 13 and 9.
- R11: `irq` also rises when status-2 AND a mask is nonzero. The mask holds bit 14 (TX empty) when control-1 bit 6 is 1. It also holds control-4 bits 3 and 0, which enable status-2 bit 3 (transmit-complete) and bit 0 (data-ready).
- R12: A control-2 write with bit 0 at 0 returns every register and both machines to the R1 state, then stores the written low 16 bits with bit 0 forced to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, same cycle as the access |
| rx_valid | input | 1 | Received item offered |
| rx_break | input | 1 | Offered item is a line break |
| rx_data | input | 8 | Received character |
| rx_ready | output | 1 | Buffer empty, item will be taken |
| tx_valid | output | 1 | Transmit byte waiting |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | Sink takes the byte |
| irq | output | 1 | Registered interrupt request |

## Verification
A receive machine stuck in FULL shows at once as `rx_ready` low, and the next receive-data read returns bit 15 set when it should not. A stuck HOLD shows as `tx_valid` high with transmit-ready reading 0. Either fault also corrupts `irq` on the cycle after. A wrong mask or gating term shows as `irq` at the wrong level exactly one cycle after a control write. A missed soft reset shows on the very next read of control-3 or baud count. The bench predicts each read and each emitted byte in a scoreboard and samples `irq` at both the cycle before its update and the cycle of it.

// File: rtl/sercsr_pkg.sv
package sercsr_pkg;

    localparam int REG_W = 16;

    // word indices (byte offset >> 2)
    localparam int W_RXD   = 'h00;
    localparam int W_TXD   = 'h10;
    localparam int W_CTL1  = 'h20;
    localparam int W_CTL2  = 'h21;
    localparam int W_CTL3  = 'h22;
    localparam int W_CTL4  = 'h23;
    localparam int W_QCTL  = 'h24;
    localparam int W_STA1  = 'h25;
    localparam int W_STA2  = 'h26;
    localparam int W_BINC  = 'h29;
    localparam int W_BMOD  = 'h2A;
    localparam int W_BCNT  = 'h2B;
    localparam int W_MSEC  = 'h2C;
    localparam int W_TEST  = 'h2D;

    // status-1 bit positions
    localparam int S1_PARERR = 15;
    localparam int S1_RTSLVL = 14;
    localparam int S1_TXRDY  = 13;
    localparam int S1_RTSCHG = 12;
    localparam int S1_ESCSEQ = 11;
    localparam int S1_FRMBAD = 10;
    localparam int S1_RXRDY  = 9;
    localparam int S1_AGEOUT = 8;
    localparam int S1_DTRCHG = 7;
    localparam int S1_RXSTAT = 6;
    localparam int S1_IRWAKE = 5;
    localparam int S1_ASLEEP = 4;

    // status-2 bit positions; TXDONE and RXDATA share positions with
    // the control-4 enables below, the interrupt mask depends on it
    localparam int S2_AUTOBD = 15;
    localparam int S2_TXEMPT = 14;
    localparam int S2_DTRFLG = 13;
    localparam int S2_IDLEC  = 12;
    localparam int S2_AUTOST = 11;
    localparam int S2_RIDLT  = 10;
    localparam int S2_IRFLG  = 8;
    localparam int S2_WKUP   = 7;
    localparam int S2_CDCHG  = 6;
    localparam int S2_CDLVL  = 5;
    localparam int S2_RTSFLG = 4;
    localparam int S2_TXDONE = 3;
    localparam int S2_BRKDET = 2;
    localparam int S2_OVRRUN = 1;
    localparam int S2_RXDATA = 0;

    // control bit positions
    localparam int C1_TXRDY_EN = 13;
    localparam int C1_RXRDY_EN = 9;
    localparam int C1_TXEMP_EN = 6;
    localparam int C2_RSTN     = 0;
    localparam int C2_TXON     = 2;
    localparam int C4_TXDN_EN  = 3;
    localparam int C4_RXDT_EN  = 0;

    // test/status bit positions
    localparam int T_TXEMPTY = 6;
    localparam int T_RXEMPTY = 5;

    // receive word flags
    localparam int RW_CHARRDY = 15;
    localparam int RW_ERR     = 14;
    localparam int RW_FRM     = 12;
    localparam int RW_BRK     = 11;

    localparam logic [REG_W-1:0] S1_RESET = REG_W'((1 << S1_TXRDY) | (1 << S1_RXSTAT) | (1 << S1_RTSLVL));
    localparam logic [REG_W-1:0] S2_RESET = REG_W'((1 << S2_TXEMPT) | (1 << S2_TXDONE) | (1 << S2_CDLVL));
    localparam logic [REG_W-1:0] S1_W1C = REG_W'((1 << S1_ASLEEP) | (1 << S1_IRWAKE) | (1 << S1_DTRCHG) |
                                                (1 << S1_AGEOUT) | (1 << S1_FRMBAD) | (1 << S1_ESCSEQ) |
                                                (1 << S1_RTSCHG) | (1 << S1_PARERR));
    localparam logic [REG_W-1:0] S2_W1C = REG_W'((1 << S2_AUTOBD) | (1 << S2_DTRFLG) | (1 << S2_IDLEC) |
                                                (1 << S2_AUTOST) | (1 << S2_RIDLT) | (1 << S2_IRFLG) |
                                                (1 << S2_WKUP) | (1 << S2_CDCHG) | (1 << S2_RTSFLG) |
                                                (1 << S2_BRKDET) | (1 << S2_OVRRUN));
    localparam logic [REG_W-1:0] C2_RESET = REG_W'(1 << C2_RSTN);
    localparam logic [REG_W-1:0] C3_RESET = REG_W'('h0700);
    localparam logic [REG_W-1:0] BCNT_RESET = REG_W'(4);
    localparam logic [REG_W-1:0] RXW_RESET = REG_W'(1 << RW_ERR);
    localparam logic [REG_W-1:0] RXW_BREAK = REG_W'((1 << RW_BRK) | (1 << RW_FRM) | (1 << RW_ERR));

    typedef enum logic { RX_EMPTY, RX_FULL } rx_state_t;
    typedef enum logic { TX_IDLE, TX_HOLD } tx_state_t;

endpackage

// File: rtl/sercsr_rx.sv
module sercsr_rx
    import sercsr_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              in_valid,
    input  logic              in_break,
    input  logic [CHAR_W-1:0] in_data,
    input  logic              take,
    output logic              in_ready,
    output logic              full,
    output logic              brk_acc,
    output logic [REG_W-1:0]  word_o
);

    rx_state_t        state_q, state_d;
    logic [REG_W-1:0] hold_q;
    logic             accept;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_EMPTY: if (in_valid) state_d = RX_FULL;   // ACCEPT
            RX_FULL:  if (take)     state_d = RX_EMPTY;  // TAKE
        endcase
        if (clr) state_d = RX_EMPTY;                     // WIPE
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RX_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready = (state_q == RX_EMPTY);
        full     = (state_q == RX_FULL);
        accept   = in_ready && in_valid && !clr;
        brk_acc  = accept && in_break;
        word_o   = hold_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      hold_q <= RXW_RESET;
        else if (clr)    hold_q <= RXW_RESET;
        else if (accept) hold_q <= in_break ? RXW_BREAK : REG_W'(in_data);
    end

    // R3
    accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !clr) |=> (full && !in_ready));

    // R4
    take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && full && !clr) |=> (in_ready && !full));

endmodule

// File: rtl/sercsr_tx.sv
module sercsr_tx
    import sercsr_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [CHAR_W-1:0] load_byte,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_data,
    output logic              idle
);

    tx_state_t         state_q, state_d;
    logic [CHAR_W-1:0] data_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: if (load)      state_d = TX_HOLD;   // LOAD
            TX_HOLD: if (out_ready) state_d = TX_IDLE;   // SEND
        endcase
        if (clr) state_d = TX_IDLE;                      // WIPE
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            data_q <= '0;
        else if (state_q == TX_IDLE && load)   data_q <= load_byte;
    end

    always_comb begin
        out_valid = (state_q == TX_HOLD);
        idle      = (state_q == TX_IDLE);
        out_data  = data_q;
    end

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !clr) |=> (out_valid && $stable(out_data)));

    // R8
    send_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !clr) |=> (!out_valid && idle));

endmodule

// File: rtl/sercsr_irq.sv
module sercsr_irq
    import sercsr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] sta1,
    input  logic [REG_W-1:0] sta2,
    input  logic [REG_W-1:0] ctl1,
    input  logic [REG_W-1:0] ctl4,
    output logic             irq_o
);

    localparam logic [REG_W-1:0] S1_SRC = REG_W'((1 << S1_TXRDY) | (1 << S1_RXRDY));
    localparam logic [REG_W-1:0] C4_SRC = REG_W'((1 << C4_TXDN_EN) | (1 << C4_RXDT_EN));

    logic [REG_W-1:0] s2_mask;
    logic             want;

    always_comb begin
        s2_mask = ctl4 & C4_SRC;
        if (ctl1[C1_TXEMP_EN]) s2_mask[S2_TXEMPT] = 1'b1;
        want = (|(sta1 & ctl1 & S1_SRC)) || (|(sta2 & s2_mask));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_o <= 1'b0;
        else        irq_o <= want;
    end

    // R10
    quiet_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl1 == '0 && ctl4 == '0) |=> !irq_o);

endmodule

// File: rtl/sercsr_top.sv
module sercsr_top
    import sercsr_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_valid,
    input  logic              rx_break,
    input  logic [CHAR_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [CHAR_W-1:0] tx_data,
    input  logic              tx_ready,
    output logic              irq
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] idx;
    logic [REG_W-1:0] wd;
    logic             wr, rd;
    logic             unused_bus_bits;

    assign idx = bus_addr[ADDR_W-1:2];
    assign wd  = bus_wdata[REG_W-1:0];
    assign wr  = bus_sel && bus_wr;
    assign rd  = bus_sel && !bus_wr;
    assign unused_bus_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:REG_W]};

    logic [REG_W-1:0] ctl1_q, ctl2_q, ctl3_q, ctl4_q, qctl_q;
    logic [REG_W-1:0] bmod_q, bcnt_q, msec_q, sta1_q, sta2_q;

    logic wr_ctl1, wr_ctl2, wr_ctl3, wr_ctl4, wr_qctl;
    logic wr_sta1, wr_sta2, wr_binc, wr_bmod, wr_msec, wr_txd;
    logic soft_rst, rx_take;

    always_comb begin
        wr_ctl1 = wr && (idx == IDX_W'(W_CTL1));
        wr_ctl2 = wr && (idx == IDX_W'(W_CTL2));
        wr_ctl3 = wr && (idx == IDX_W'(W_CTL3));
        wr_ctl4 = wr && (idx == IDX_W'(W_CTL4));
        wr_qctl = wr && (idx == IDX_W'(W_QCTL));
        wr_sta1 = wr && (idx == IDX_W'(W_STA1));
        wr_sta2 = wr && (idx == IDX_W'(W_STA2));
        wr_binc = wr && (idx == IDX_W'(W_BINC));
        wr_bmod = wr && (idx == IDX_W'(W_BMOD));
        wr_msec = wr && (idx == IDX_W'(W_MSEC));
        wr_txd  = wr && (idx == IDX_W'(W_TXD));
        soft_rst = wr_ctl2 && !wd[C2_RSTN];
        rx_take  = rd && (idx == IDX_W'(W_RXD));
    end

    logic             rx_full, rx_brk;
    logic [REG_W-1:0] rx_word;
    logic             tx_idle;

    sercsr_rx #(.CHAR_W(CHAR_W)) rx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (soft_rst),
        .in_valid (rx_valid),
        .in_break (rx_break),
        .in_data  (rx_data),
        .take     (rx_take),
        .in_ready (rx_ready),
        .full     (rx_full),
        .brk_acc  (rx_brk),
        .word_o   (rx_word)
    );

    sercsr_tx #(.CHAR_W(CHAR_W)) tx_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (soft_rst),
        .load      (wr_txd && ctl2_q[C2_TXON]),
        .load_byte (wd[CHAR_W-1:0]),
        .out_ready (tx_ready),
        .out_valid (tx_valid),
        .out_data  (tx_data),
        .idle      (tx_idle)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1_q <= '0;       ctl2_q <= C2_RESET;   ctl3_q <= C3_RESET;
            ctl4_q <= '0;       qctl_q <= '0;         bmod_q <= '0;
            bcnt_q <= BCNT_RESET; msec_q <= '0;
            sta1_q <= S1_RESET; sta2_q <= S2_RESET;
        end else if (soft_rst) begin
            ctl1_q <= '0;       ctl2_q <= wd | C2_RESET; ctl3_q <= C3_RESET;
            ctl4_q <= '0;       qctl_q <= '0;         bmod_q <= '0;
            bcnt_q <= BCNT_RESET; msec_q <= '0;
            sta1_q <= S1_RESET; sta2_q <= S2_RESET;
        end else begin
            if (wr_ctl1) ctl1_q <= wd;
            if (wr_ctl2) ctl2_q <= wd;
            if (wr_ctl3) ctl3_q <= wd;
            if (wr_ctl4) ctl4_q <= wd;
            if (wr_qctl) qctl_q <= wd;
            if (wr_bmod) bmod_q <= wd;
            if (wr_binc) bcnt_q <= wd;
            if (wr_msec) msec_q <= wd;
            if (wr_sta1) sta1_q <= sta1_q & ~(wd & S1_W1C);
            if (wr_sta2 || rx_brk) begin
                sta2_q <= (sta2_q & ~(wr_sta2 ? (wd & S2_W1C) : '0))
                        | (rx_brk ? REG_W'(1 << S2_BRKDET) : '0);
            end
        end
    end

    logic [REG_W-1:0] sta1_v, sta2_v, test_v, rxd_v;

    always_comb begin
        sta1_v = sta1_q;
        sta1_v[S1_TXRDY] = tx_idle;
        sta1_v[S1_RXRDY] = rx_full;
        sta2_v = sta2_q;
        sta2_v[S2_TXDONE] = tx_idle;
        sta2_v[S2_RXDATA] = rx_full;
        test_v = '0;
        test_v[T_TXEMPTY] = 1'b1;
        test_v[T_RXEMPTY] = !rx_full;
        rxd_v = rx_word;
        if (rx_full) rxd_v[RW_CHARRDY] = 1'b1;
    end

    logic [REG_W-1:0] rsel;

    always_comb begin
        rsel = '0;
        if (rd) begin
            unique case (idx)
                IDX_W'(W_RXD):  rsel = rxd_v;
                IDX_W'(W_CTL1): rsel = ctl1_q;
                IDX_W'(W_CTL2): rsel = ctl2_q;
                IDX_W'(W_CTL3): rsel = ctl3_q;
                IDX_W'(W_CTL4): rsel = ctl4_q;
                IDX_W'(W_QCTL): rsel = qctl_q;
                IDX_W'(W_STA1): rsel = sta1_v;
                IDX_W'(W_STA2): rsel = sta2_v;
                IDX_W'(W_BINC): rsel = '0;
                IDX_W'(W_BMOD): rsel = bmod_q;
                IDX_W'(W_BCNT): rsel = bcnt_q;
                IDX_W'(W_MSEC): rsel = msec_q;
                IDX_W'(W_TEST): rsel = test_v;
                default:        rsel = '0;
            endcase
        end
        bus_rdata = DATA_W'(rsel);
    end

    sercsr_irq irq_i (
        .clk   (clk),
        .rst_n (rst_n),
        .sta1  (sta1_v),
        .sta2  (sta2_v),
        .ctl1  (ctl1_q),
        .ctl4  (ctl4_q),
        .irq_o (irq)
    );

    // R12
    soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (ctl2_q[C2_RSTN] && rx_ready && !tx_valid && ctl3_q == C3_RESET));

    // R6
    sta1_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sta1 && !soft_rst) |=> ((sta1_q & ~S1_W1C) == ($past(sta1_q) & ~S1_W1C)));

endmodule

// File: tb/sercsr_top_tb_top.sv
module sercsr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, tx_ready = 1'b0, irq;
    logic [7:0]  tx_data;

    always #2.5 clk = ~clk;

    sercsr_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_break(rx_break), .rx_data(rx_data),
        .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .irq(irq)
    );

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] rd_exp_q[$];
    string       rd_tag_q[$];
    logic [7:0]  tx_exp_q[$];

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // driver tasks
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag);
        @(posedge clk); #1;
        rd_exp_q.push_back(e); rd_tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic txw(input logic [31:0] d, input bit emit);
        if (emit) tx_exp_q.push_back(d[7:0]);
        wr(12'h040, d);
    endtask

    task automatic rxp(input logic [7:0] c, input logic brk);
        @(posedge clk); #1;
        rx_valid = 1'b1; rx_data = c; rx_break = brk;
        @(posedge clk); #1;
        rx_valid = 1'b0; rx_break = 1'b0;
    endtask

    task automatic sink_pulse();
        @(posedge clk); #1; tx_ready = 1'b1;
        @(posedge clk); #1; tx_ready = 1'b0;
    endtask

    task automatic irq_after(input logic exp, input string tag);
        @(negedge clk);
        @(negedge clk);
        chk(tag, {31'b0, irq}, {31'b0, exp});
    endtask

    // monitor: scoreboard for reads and emitted bytes
    always @(negedge clk) begin : mon
        logic [31:0] e;
        string t;
        logic [7:0] b;
        if (bus_sel && !bus_wr) begin
            if (rd_exp_q.size() == 0) chk("R2 unexpected read", 32'h1, 32'h0);
            else begin
                e = rd_exp_q.pop_front(); t = rd_tag_q.pop_front();
                chk(t, bus_rdata, e);
            end
        end
        if (tx_valid && tx_ready) begin
            if (tx_exp_q.size() == 0) chk("R9 unexpected tx byte", {24'b0, tx_data}, 32'hFFFF_FFFF);
            else begin
                b = tx_exp_q.pop_front();
                chk("R8 tx byte", {24'b0, tx_data}, {24'b0, b});
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 50000) begin
            errors++; checks++;
            $display("FAIL watchdog all-requirements actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
        chk("R1 tx_valid", {31'b0, tx_valid}, 32'h0);
        rd(12'h080, 32'h0000, "R1 ctl1");
        rd(12'h084, 32'h0001, "R1 ctl2");
        rd(12'h088, 32'h0700, "R1 ctl3");
        rd(12'h0A8, 32'h0000, "R1 modulator");
        rd(12'h0AC, 32'h0004, "R1 baud count");
        rd(12'h094, 32'h6040, "R1 status1");
        rd(12'h098, 32'h4028, "R1 status2");
        rd(12'h0B4, 32'h0060, "R1 test");
        rd(12'h000, 32'h4000, "R1 rx word (R4 empty read)");

        // R2 decode
        wr(12'h088, 32'hABCD_1234); rd(12'h088, 32'h1234, "R2 ctl3 low16");
        wr(12'h090, 32'h0000_5A5A); rd(12'h090, 32'h5A5A, "R2 queue ctl");
        wr(12'h0B0, 32'h0000_00FF); rd(12'h0B0, 32'h00FF, "R2 msec");
        wr(12'h0A8, 32'h0000_0077); rd(12'h0A8, 32'h0077, "R2 modulator");
        wr(12'h0A4, 32'h0000_1234); rd(12'h0AC, 32'h1234, "R2 incr->count");
        rd(12'h0A4, 32'h0000, "R2 incr reads 0");
        wr(12'h0AC, 32'h0000_9999); rd(12'h0AC, 32'h1234, "R2 count write ignored");
        wr(12'h0B4, 32'h0000_FFFF); rd(12'h0B4, 32'h0060, "R2 test write ignored");
        wr(12'h3FC, 32'hFFFF_FFFF); rd(12'h3FC, 32'h0, "R2 unknown reads 0");
        rd(12'h004, 32'h0, "R2 unknown 0x004");

        // R3 / R4 receive
        rxp(8'h41, 1'b0);
        @(negedge clk); chk("R3 rx_ready low when full", {31'b0, rx_ready}, 32'h0);
        rd(12'h094, 32'h6240, "R3 status1 rxrdy");
        rd(12'h098, 32'h4029, "R3 status2 rxdata");
        rd(12'h0B4, 32'h0040, "R3 test rx-empty clear");
        rxp(8'h42, 1'b0);
        rd(12'h000, 32'h8041, "R3 full ignores second char / R4 charrdy");
        rd(12'h094, 32'h6040, "R4 status1 after take");
        rd(12'h000, 32'h0041, "R4 repeat read no charrdy");
        @(negedge clk); chk("R4 rx_ready back", {31'b0, rx_ready}, 32'h1);

        // R5 break, R7 / R6 write-1-to-clear
        rxp(8'h00, 1'b1);
        rd(12'h098, 32'h402D, "R5 status2 break detect");
        rd(12'h000, 32'hD800, "R5 break word");
        rd(12'h098, 32'h402C, "R5 break bit stays");
        wr(12'h098, 32'h0000_FFFF); rd(12'h098, 32'h4028, "R7 w1c status2");
        wr(12'h094, 32'h0000_FFFF); rd(12'h094, 32'h6040, "R6 status1 ignores non-w1c");

        // R8 / R9 transmit
        txw(32'h1A5, 1'b0);
        @(negedge clk); chk("R9 dropped when disabled", {31'b0, tx_valid}, 32'h0);
        wr(12'h084, 32'h0005);
        txw(32'h3C5, 1'b1);
        @(negedge clk);
        chk("R8 tx_valid", {31'b0, tx_valid}, 32'h1);
        chk("R8 tx_data", {24'b0, tx_data}, 32'hC5);
        rd(12'h094, 32'h4040, "R8 status1 txrdy low");
        rd(12'h098, 32'h4020, "R8 status2 txdone low");
        txw(32'h77, 1'b0);
        @(negedge clk); chk("R9 pending byte kept", {24'b0, tx_data}, 32'hC5);
        sink_pulse();
        @(negedge clk); chk("R8 released", {31'b0, tx_valid}, 32'h0);
        rd(12'h094, 32'h6040, "R8 status1 txrdy back");

        // R10 interrupt from status1
        wr(12'h080, 32'h2000);
        @(negedge clk); chk("R10 irq one cycle late", {31'b0, irq}, 32'h0);
        @(negedge clk); chk("R10 irq txrdy", {31'b0, irq}, 32'h1);
        wr(12'h080, 32'h0200); irq_after(1'b0, "R10 rxrdy idle");
        rxp(8'h55, 1'b0);       irq_after(1'b1, "R10 rxrdy set");
        rd(12'h000, 32'h8055, "R10 take");
        irq_after(1'b0, "R10 rxrdy cleared");

        // R11 interrupt from status2
        wr(12'h080, 32'h0040); irq_after(1'b1, "R11 tx empty enable");
        wr(12'h080, 32'h0000); irq_after(1'b0, "R11 off");
        wr(12'h08C, 32'h0008); irq_after(1'b1, "R11 txdone enable");
        txw(32'h11, 1'b1);     irq_after(1'b0, "R11 txdone low while pending");
        sink_pulse();          irq_after(1'b1, "R11 txdone back");
        wr(12'h08C, 32'h0001); irq_after(1'b0, "R11 rxdata idle");
        rxp(8'h22, 1'b0);      irq_after(1'b1, "R11 rxdata set");
        rd(12'h000, 32'h8022, "R11 take");
        irq_after(1'b0, "R11 rxdata cleared");

        // R12 soft reset with both machines busy
        wr(12'h088, 32'h0055);
        txw(32'h99, 1'b0);
        rxp(8'h33, 1'b0);
        wr(12'h084, 32'h0002);
        @(negedge clk);
        chk("R12 tx cleared", {31'b0, tx_valid}, 32'h0);
        chk("R12 rx cleared", {31'b0, rx_ready}, 32'h1);
        rd(12'h084, 32'h0003, "R12 ctl2 keeps value with bit0");
        rd(12'h088, 32'h0700, "R12 ctl3");
        rd(12'h0AC, 32'h0004, "R12 count");
        rd(12'h08C, 32'h0000, "R12 ctl4");
        rd(12'h000, 32'h4000, "R12 rx word");
        rd(12'h098, 32'h4028, "R12 status2");
        irq_after(1'b0, "R12 irq");

        repeat (3) @(negedge clk);
        chk("R8 all bytes sent", tx_exp_q.size(), 0);
        chk("R2 all reads seen", rd_exp_q.size(), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule